// File: doc/BRIEF.md
# Gate-Drive Protection Fault Controller

This block sits between the protection comparators of a three-phase half-bridge driver and its gate output channels. It reads an overcurrent comparator bit that has already been synchronised, an undervoltage bit for the shared logic and low-side supply, one undervoltage bit for each floating high-side supply, an active-high enable, and a pulse from the channel block that marks any gate output turning on. From these it drives three outputs. The first is a global shutdown that forces all six gate outputs off. The second is a high-side inhibit for each phase. The third is an active-low fault flag that models an open-drain pin: 0 pulls the pin low, and 1 releases it.

The two fault classes behave differently. An overcurrent event is latched. It is released by a programmable clear timer, and that timer runs only while the trip input is low. A trip that arrives while the timer is running sends the timer back to zero. The overcurrent input is masked for a programmable blanking window after every turn-on pulse, so that switching spikes are ignored. A shared-supply undervoltage is not latched: shutdown and the flag follow it directly. A high-side supply undervoltage blocks only the high side of its own phase and leaves the flag alone. Driving enable low shuts every output down without raising the flag. All outputs are registered.

Top module: `fault_guard`

## Requirements
- R1: With reset released and all inputs benign (trip 0, undervoltage bits 0, enable 1, no turn-on pulse), `shut_o`=0, `fault_n_o`=1 and `hs_inhibit_o`=0.
- R2: If `trip_i` is high at a rising edge outside the blanking window, `shut_o`=1 and `fault_n_o`=0 from the second rising edge after it.
- R3: An overcurrent fault stays latched while `trip_i` is high. It is released once `trip_i` has been low at CLR_CYC consecutive rising edges, and the outputs reflect the release one edge later.
- R4: A high `trip_i` during the clear countdown sends the countdown back to zero, so a full CLR_CYC low edges are needed again.
- R5: After a rising edge with `turn_on_i`=1, `trip_i` is ignored at the next BLANK_CYC rising edges. A new turn-on pulse starts the window again.
- R6: `vcc_low_i`=1 at a rising edge makes `shut_o`=1 and `fault_n_o`=0 after that edge. Both return to their inactive values one edge after `vcc_low_i` goes back to 0, with no latching.
- R7: `vbs_low_i[p]`=1 sets `hs_inhibit_o[p]` after the next edge. Bit p of these vectors is phase p. This input has no effect on `shut_o`, on `fault_n_o` or on the other phases.
- R8: `en_i`=0 makes `shut_o`=1 after the next edge while `fault_n_o` stays 1.
- R9: During reset and just after it, the outputs are the no-fault values, except where undervoltage or enable inputs that are already active force them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Synchronised overcurrent comparator bit, high = trip |
| vcc_low_i | input | 1 | Shared supply undervoltage, high = low supply |
| vbs_low_i | input | NUM_PH | High-side supply undervoltage, one bit per phase |
| en_i | input | 1 | Enable, low forces all outputs off |
| turn_on_i | input | 1 | Pulse from the channel block when any gate output turns on |
| shut_o | output | 1 | Global shutdown of all gate outputs |
| hs_inhibit_o | output | NUM_PH | Per-phase high-side inhibit |
| fault_n_o | output | 1 | Fault flag, 0 = asserted, 1 = released |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `trip_i` is already free of metastability, and that BLANK_CYC and CLR_CYC are at least 1 and 2. The bench changes every input only on the falling clock edge. It builds the block with short blanking and clear lengths, so that each countdown fits in a few dozen cycles. It keeps `turn_on_i` to single-cycle pulses, as the channel block would drive it.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef struct packed {
    logic oc;   // latched overcurrent
    logic uv;   // shared-supply undervoltage (not latched)
  } fg_cause_t;
endpackage

// File: rtl/fg_blank.sv
module fg_blank #(
  parameter int BLANK_CYC = 38
) (
  input  logic clk,
  input  logic rst,
  input  logic turn_on_i,
  input  logic trip_i,
  output logic trip_q_o,
  output logic blank_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (turn_on_i) begin
      cnt_q <= BW'(BLANK_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign blank_o  = (cnt_q != '0);
  assign trip_q_o = trip_i & ~blank_o;

  // R5: a turn-on pulse always opens a blanking window
  a_r5_blank_opens: assert property (@(posedge clk) disable iff (rst)
    turn_on_i |=> blank_o);
  // R5: nothing passes while blanked
  a_r5_blank_masks: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> !trip_q_o);
endmodule

// File: rtl/fg_oc_latch.sv
module fg_oc_latch #(
  parameter int CLR_CYC = 412500
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_q_i,
  input  logic trip_i,
  output logic oc_o
);
  localparam int CW = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;

  logic          oc_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (trip_i) begin
        cnt_q <= '0;
      end else if (oc_q) begin
        if (cnt_q == CW'(CLR_CYC - 1)) begin
          cnt_q <= '0;
          oc_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (trip_q_i) oc_q <= 1'b1;
    end
  end

  assign oc_o = oc_q;

  // R2: a qualified trip latches the fault
  a_r2_latch_set: assert property (@(posedge clk) disable iff (rst)
    trip_q_i |=> oc_q);
  // R3: the fault cannot clear while the trip input is high
  a_r3_hold_on_trip: assert property (@(posedge clk) disable iff (rst)
    (oc_q && trip_i) |=> oc_q);
  // R4: release only follows an edge with the trip input low
  a_r4_release_low: assert property (@(posedge clk) disable iff (rst)
    $fell(oc_q) |-> !$past(trip_i));
endmodule

// File: rtl/fg_out_stage.sv
module fg_out_stage
  import fg_pkg::*;
#(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  fg_cause_t         cause_i,
  input  logic              en_i,
  input  logic [NUM_PH-1:0] vbs_low_i,
  output logic              shut_o,
  output logic [NUM_PH-1:0] hs_inhibit_o,
  output logic              fault_n_o
);
  logic oc_eff;

  always_comb oc_eff = cause_i.oc & ~rst;

  always_ff @(posedge clk) begin
    shut_o    <= oc_eff | cause_i.uv | ~en_i;
    fault_n_o <= ~(oc_eff | cause_i.uv);
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    always_ff @(posedge clk) hs_inhibit_o[p] <= vbs_low_i[p];

    // R7: each inhibit follows its own supply bit one edge later
    a_r7_inhibit: assert property (@(posedge clk) disable iff (rst)
      hs_inhibit_o[p] == $past(vbs_low_i[p]));
  end

  // R6: shared undervoltage shuts down and flags
  a_r6_uv_flag: assert property (@(posedge clk) disable iff (rst)
    cause_i.uv |=> (shut_o && !fault_n_o));
  // R8: enable low shuts down silently
  a_r8_en_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !cause_i.oc && !cause_i.uv) |=> (shut_o && fault_n_o));
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int NUM_PH    = 3,
  parameter int BLANK_CYC = 38,
  parameter int CLR_CYC   = 412500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trip_i,
  input  logic              vcc_low_i,
  input  logic [NUM_PH-1:0] vbs_low_i,
  input  logic              en_i,
  input  logic              turn_on_i,
  output logic              shut_o,
  output logic [NUM_PH-1:0] hs_inhibit_o,
  output logic              fault_n_o
);
  logic      trip_q;
  logic      blank;
  logic      oc;
  fg_cause_t cause;

  fg_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .turn_on_i(turn_on_i), .trip_i(trip_i),
    .trip_q_o(trip_q), .blank_o(blank)
  );

  fg_oc_latch #(.CLR_CYC(CLR_CYC)) u_oc (
    .clk(clk), .rst(rst), .trip_q_i(trip_q), .trip_i(trip_i), .oc_o(oc)
  );

  always_comb begin
    cause.oc = oc;
    cause.uv = vcc_low_i;
  end

  fg_out_stage #(.NUM_PH(NUM_PH)) u_out (
    .clk(clk), .rst(rst), .cause_i(cause), .en_i(en_i),
    .vbs_low_i(vbs_low_i), .shut_o(shut_o),
    .hs_inhibit_o(hs_inhibit_o), .fault_n_o(fault_n_o)
  );

  // R1: the flag is never asserted without shutdown
  a_r1_flag_implies_shut: assert property (@(posedge clk) disable iff (rst)
    !fault_n_o |-> shut_o);
endmodule

// File: tb/test_fault_guard.sv
module test_fault_guard;
  localparam int NP  = 3;
  localparam int BLK = 4;
  localparam int CLR = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip = 1'b0, vcc_low = 1'b0, en = 1'b1, ton = 1'b0;
  logic [NP-1:0] vbs_low = '0;
  logic shut, fault_n;
  logic [NP-1:0] inh;

  int total = 0, bad = 0;
  string req = "R9";
  bit done = 0;

  always #2 clk = ~clk;

  fault_guard #(.NUM_PH(NP), .BLANK_CYC(BLK), .CLR_CYC(CLR)) i_fault_guard (
    .clk(clk), .rst(rst), .trip_i(trip), .vcc_low_i(vcc_low),
    .vbs_low_i(vbs_low), .en_i(en), .turn_on_i(ton),
    .shut_o(shut), .hs_inhibit_o(inh), .fault_n_o(fault_n)
  );

  // behavioural reference
  int m_blank = 0, m_cnt = 0;
  bit m_oc = 0, m_valid = 0;
  logic e_shut, e_fn;
  logic [NP-1:0] e_inh;

  always @(posedge clk) begin
    bit q;
    if (rst) begin
      e_shut = vcc_low | ~en; e_fn = ~vcc_low; e_inh = vbs_low;
      m_blank = 0; m_cnt = 0; m_oc = 0;
    end else begin
      e_shut = m_oc | vcc_low | ~en; e_fn = ~(m_oc | vcc_low); e_inh = vbs_low;
      q = trip && (m_blank == 0);
      if (trip) m_cnt = 0;
      else if (m_oc) begin
        m_cnt++;
        if (m_cnt == CLR) begin m_oc = 0; m_cnt = 0; end
      end
      if (q) m_oc = 1;
      if (ton) m_blank = BLK;
      else if (m_blank > 0) m_blank--;
    end
    m_valid = 1;
  end

  always @(negedge clk) if (m_valid && !done) begin
    total++;
    if (shut !== e_shut || fault_n !== e_fn || inh !== e_inh) begin
      bad++;
      $display("FAIL %s: shut/fault_n/inh actual=%b/%b/%b expected=%b/%b/%b",
               req, shut, fault_n, inh, e_shut, e_fn, e_inh);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", r, act, exp);
    end
  endtask

  initial begin
    // R9: reset with undervoltage already active
    vcc_low = 1'b1; vbs_low = 3'b010;
    tick(3);
    chk("R9", shut, 1'b1); chk("R9", fault_n, 1'b0); chk("R9", inh[1], 1'b1);
    vcc_low = 1'b0; vbs_low = '0;
    tick(2);
    rst = 1'b0;
    tick(2);
    req = "R1";
    chk("R1", shut, 1'b0); chk("R1", fault_n, 1'b1); chk("R1", |inh, 1'b0);

    // R2 and R3: trip, hold, timed release
    req = "R2";
    trip = 1'b1; tick(2);
    chk("R2", shut, 1'b1); chk("R2", fault_n, 1'b0);
    req = "R3";
    tick(3);
    trip = 1'b0; tick(CLR);
    chk("R3", fault_n, 1'b0);
    tick(1);
    chk("R3", fault_n, 1'b1); chk("R3", shut, 1'b0);

    // R4: retrip during countdown restarts it
    req = "R4";
    trip = 1'b1; tick(1); trip = 1'b0; tick(CLR - 3);
    trip = 1'b1; tick(1); trip = 1'b0; tick(CLR - 1);
    chk("R4", fault_n, 1'b0);
    tick(3);
    chk("R4", fault_n, 1'b1);

    // R5: blanking masks the trip, and a new pulse restarts the window
    req = "R5";
    ton = 1'b1; tick(1); ton = 1'b0;
    trip = 1'b1; tick(BLK - 2);
    ton = 1'b1; tick(1); ton = 1'b0; tick(BLK - 1);
    trip = 1'b0; tick(3);
    chk("R5", fault_n, 1'b1); chk("R5", shut, 1'b0);
    ton = 1'b1; tick(1); ton = 1'b0; tick(BLK);
    trip = 1'b1; tick(1); trip = 1'b0; tick(2);
    chk("R5", fault_n, 1'b0);
    tick(CLR + 2);

    // R6: non-latched undervoltage
    req = "R6";
    vcc_low = 1'b1; tick(1);
    chk("R6", fault_n, 1'b0); chk("R6", shut, 1'b1);
    tick(3); vcc_low = 1'b0; tick(1);
    chk("R6", fault_n, 1'b1); chk("R6", shut, 1'b0);

    // R7: per-phase high-side undervoltage
    req = "R7";
    for (int p = 0; p < NP; p++) begin
      vbs_low = NP'(1) << p; tick(2);
      chk("R7", inh[p], 1'b1); chk("R7", fault_n, 1'b1); chk("R7", shut, 1'b0);
    end
    vbs_low = 3'b101; tick(2);
    chk("R7", inh[1], 1'b0);
    vbs_low = '0; tick(2);

    // R8: enable low
    req = "R8";
    en = 1'b0; tick(1);
    chk("R8", shut, 1'b1); chk("R8", fault_n, 1'b1);
    trip = 1'b1; tick(1); trip = 1'b0; tick(2);
    chk("R8", fault_n, 1'b0);
    en = 1'b1; tick(CLR + 3);
    chk("R8", shut, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule